// File: doc/BRIEF.md
# Limit-Compare Periodic Tick Timer Bank

This block holds a bank of up-counters: one per processor plus one shared system counter. Each counter advances once per clock and is compared with a limit that software programs. When the count equals a non-zero limit, the counter returns to zero on the next edge and latches a level interrupt. The interrupt stays high until software acknowledges it.

The acknowledge is a side effect of reading the counter's limit word. A second address for the same limit lets software change the period without touching the pending interrupt. The count is readable at any time, so the system counter can also serve as a time base. A shared control word holds one mode bit per processor counter. When the bit is set, that counter runs freely as a plain up-counter and never raises its interrupt.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every count, every limit, every interrupt output, every mode bit and `bus_rdata` are zero.
- R2: In timer mode with a non-zero limit L, the count steps 0, 1, …, L. On the edge where the count equals L, the count goes to 0 and the interrupt is set. The interrupt therefore first rises L+1 edges after a restarting limit write.
- R3: A set interrupt stays set until its limit word (word 0) is read. That read clears the interrupt on the same edge.
- R4: If a limit-word read lands on the edge where the count matches the limit, the interrupt is set after that edge. A new match wins over the acknowledge.
- R5: A write to the limit word (word 0) loads the limit from the low bits of `bus_wdata` and restarts the count at 0. It does not change the interrupt.
- R6: A write to the alias word (word 2) loads the limit without restarting the count and without changing the interrupt. The compare on that edge still uses the old limit.
- R7: In timer mode a limit of 0 stops the counter: the count holds its value and no interrupt is raised.
- R8: The count word (word 1) returns the current count. Reading words 1 or 2 does not acknowledge the interrupt. Writes to word 1 are ignored.
- R9: The control word (word 3 of the system block) holds one mode bit per processor counter, with bit i for counter i. A 1 makes counter i free-run: it increments every edge, wraps modulo 2^CNT_W, ignores its limit and never sets its interrupt. Writing 0 returns all processor counters to timer mode. The system counter is always in timer mode.
- R10: Address bits [high:2] select the block: values 0..N_CPU-1 are the processor counters and N_CPU is the system counter. Bits [1:0] select the word. `bus_rdata` shows the addressed value on the cycle after a read, zero-extended. It is zero after any cycle without a read, for word 3 of a processor block, and for an unused block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(N_CPU+1)+2 | Block index and word select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| cpu_irq | output | N_CPU | Per-processor tick interrupts |
| sys_irq | output | 1 | System tick interrupt |

## Verification
Every register update happens on the edge that carries the access, and read data comes out one edge later. The bench therefore checks `bus_rdata` and the interrupt outputs on the falling edge right after the access edge. Expected counts come from counting edges since the last restarting write. For a limit L, the interrupt is due on edge L+1 after that write, so the bench samples at edges L and L+1. The match-versus-acknowledge collision and the period change through the alias are placed on exact edges with idle gaps that are worked out in advance. User-mode wrap is checked at counts 255 and 0 with an 8-bit counter.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // Word select inside one counter block (address bits [1:0])
    typedef enum logic [1:0] {
        WORD_LIMIT   = 2'd0,
        WORD_COUNT   = 2'd1,
        WORD_LIMIT_K = 2'd2,
        WORD_CTRL    = 2'd3
    } word_e;

endpackage

// File: rtl/tick_addr_decode.sv
module tick_addr_decode
    import tick_timer_pkg::*;
#(
    parameter int N_CPU  = 2,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [N_CPU:0]      wr_limit_o,
    output logic [N_CPU:0]      wr_keep_o,
    output logic [N_CPU:0]      rd_ack_o,
    output logic                wr_ctrl_o
);
    localparam int NB    = N_CPU + 1;
    localparam int BLK_W = ADDR_W - 2;

    logic [BLK_W-1:0] blk;
    word_e            word;

    assign blk  = addr_i[ADDR_W-1:2];
    assign word = word_e'(addr_i[1:0]);

    for (genvar b = 0; b < NB; b++) begin : g_blk
        logic hit;
        assign hit           = sel_i && (blk == BLK_W'(b));
        assign wr_limit_o[b] = hit &&  we_i && (word == WORD_LIMIT);
        assign wr_keep_o[b]  = hit &&  we_i && (word == WORD_LIMIT_K);
        assign rd_ack_o[b]   = hit && !we_i && (word == WORD_LIMIT);
    end

    assign wr_ctrl_o = sel_i && we_i && (blk == BLK_W'(N_CPU)) && (word == WORD_CTRL);

    // R10: one access touches at most one register
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_limit_o, wr_keep_o, rd_ack_o, wr_ctrl_o}));

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode_i,
    input  logic             wr_limit_i,
    input  logic             wr_keep_i,
    input  logic             rd_ack_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] limit_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] limit;
        logic             irq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    match;
    logic    stopped;

    always_comb begin
        match   = !user_mode_i && (st_q.limit != '0) && (st_q.count == st_q.limit);
        stopped = !user_mode_i && (st_q.limit == '0);
        st_d    = st_q;

        if (match)
            st_d.count = '0;
        else if (!stopped)
            st_d.count = st_q.count + 1'b1;

        if (rd_ack_i)
            st_d.irq = 1'b0;
        if (match)
            st_d.irq = 1'b1;

        if (wr_limit_i) begin
            st_d.limit = wdata_i;
            st_d.count = '0;
        end else if (wr_keep_i) begin
            st_d.limit = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign limit_o = st_q.limit;
    assign irq_o   = st_q.irq;

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match && !wr_limit_i |=> irq_o && (count_o == '0));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && rd_ack_i && !match |=> !irq_o);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !rd_ack_i |=> irq_o);

    p_match_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match && rd_ack_i |=> irq_o);

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_limit_i |=> (count_o == '0) && (limit_o == $past(wdata_i)) && (irq_o == $past(irq_o || match)));

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_keep_i && !wr_limit_i && !rd_ack_i |=> (limit_o == $past(wdata_i)) && (irq_o == $past(irq_o || match)));

    p_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode_i && (limit_o == '0) && !wr_limit_i |=> $stable(count_o));

    p_user_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_i && !irq_o |=> !irq_o);

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tick_timer_pkg::*;
#(
    parameter int N_CPU  = 2,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_we,
    input  logic [$clog2(N_CPU+1)+1:0]     bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [N_CPU-1:0]               cpu_irq,
    output logic                           sys_irq
);
    localparam int NB     = N_CPU + 1;
    localparam int BLK_W  = $clog2(N_CPU + 1);
    localparam int ADDR_W = BLK_W + 2;

    typedef struct packed {
        logic [N_CPU-1:0]  mode;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N_CPU:0]   wr_limit, wr_keep, rd_ack;
    logic             wr_ctrl;
    logic [CNT_W-1:0] cnt_v [NB];
    logic [CNT_W-1:0] lim_v [NB];
    logic [NB-1:0]    irq_v;

    tick_addr_decode #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel),
        .we_i       (bus_we),
        .addr_i     (bus_addr),
        .wr_limit_o (wr_limit),
        .wr_keep_o  (wr_keep),
        .rd_ack_o   (rd_ack),
        .wr_ctrl_o  (wr_ctrl)
    );

    for (genvar b = 0; b < NB; b++) begin : g_cnt
        logic user;
        if (b < N_CPU) begin : g_cpu
            assign user = st_q.mode[b];
        end else begin : g_sys
            assign user = 1'b0;
        end

        tick_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .user_mode_i (user),
            .wr_limit_i  (wr_limit[b]),
            .wr_keep_i   (wr_keep[b]),
            .rd_ack_i    (rd_ack[b]),
            .wdata_i     (bus_wdata[CNT_W-1:0]),
            .count_o     (cnt_v[b]),
            .limit_o     (lim_v[b]),
            .irq_o       (irq_v[b])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_ctrl)
            st_d.mode = bus_wdata[N_CPU-1:0];
        if (bus_sel && !bus_we) begin
            for (int b = 0; b < NB; b++) begin
                if (bus_addr[ADDR_W-1:2] == BLK_W'(b)) begin
                    unique case (word_e'(bus_addr[1:0]))
                        WORD_LIMIT, WORD_LIMIT_K: st_d.rdata = DATA_W'(lim_v[b]);
                        WORD_COUNT:               st_d.rdata = DATA_W'(cnt_v[b]);
                        WORD_CTRL:                st_d.rdata = (b == N_CPU) ? DATA_W'(st_q.mode) : '0;
                        default:                  st_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign cpu_irq   = irq_v[N_CPU-1:0];
    assign sys_irq   = irq_v[N_CPU];

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> (bus_rdata == '0));

    p_mode_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (st_q.mode == $past(bus_wdata[N_CPU-1:0])));

endmodule

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;
    localparam int N_CPU  = 2;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;
    localparam int NVEC   = 24;

    // vector: idle[3:0], we, addr[3:0], data[15:0] (wdata or expected rdata), expected sys_irq
    localparam logic [25:0] VEC [NVEC] = '{
        {4'd0, 1'b0, 4'd8,  16'd0,   1'b0},
        {4'd0, 1'b0, 4'd9,  16'd0,   1'b0},
        {4'd0, 1'b1, 4'd8,  16'd5,   1'b0},
        {4'd2, 1'b0, 4'd9,  16'd2,   1'b0},
        {4'd0, 1'b0, 4'd9,  16'd3,   1'b0},
        {4'd0, 1'b0, 4'd9,  16'd4,   1'b0},
        {4'd0, 1'b0, 4'd9,  16'd5,   1'b1},
        {4'd0, 1'b0, 4'd9,  16'd0,   1'b1},
        {4'd0, 1'b0, 4'd10, 16'd5,   1'b1},
        {4'd0, 1'b0, 4'd8,  16'd5,   1'b0},
        {4'd0, 1'b1, 4'd10, 16'd7,   1'b0},
        {4'd2, 1'b0, 4'd9,  16'd6,   1'b0},
        {4'd0, 1'b0, 4'd9,  16'd7,   1'b1},
        {4'd7, 1'b0, 4'd8,  16'd7,   1'b1},
        {4'd0, 1'b0, 4'd8,  16'd7,   1'b0},
        {4'd0, 1'b1, 4'd9,  16'd100, 1'b0},
        {4'd0, 1'b0, 4'd9,  16'd2,   1'b0},
        {4'd0, 1'b1, 4'd8,  16'd0,   1'b0},
        {4'd3, 1'b0, 4'd9,  16'd0,   1'b0},
        {4'd0, 1'b1, 4'd10, 16'd2,   1'b0},
        {4'd2, 1'b0, 4'd9,  16'd2,   1'b1},
        {4'd1, 1'b1, 4'd8,  16'd9,   1'b1},
        {4'd0, 1'b0, 4'd9,  16'd0,   1'b1},
        {4'd0, 1'b0, 4'd8,  16'd9,   1'b0}
    };

    // which requirement each vector exercises
    localparam string VREQ [NVEC] = '{
        "R1", "R7", "R5", "R2", "R2", "R2", "R2", "R2", "R8", "R3", "R6", "R6",
        "R6", "R4", "R3", "R8", "R8", "R7", "R7", "R6", "R6", "R5", "R5", "R3"
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [N_CPU-1:0]  cpu_irq;
    logic              sys_irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    tick_timer_bank #(.N_CPU(N_CPU), .CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq),
        .sys_irq   (sys_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; spans exactly one rising edge
    task automatic acc(input bit we, input logic [3:0] a, input logic [DATA_W-1:0] d);
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 cpu_irq", int'(cpu_irq), 0);
        chk("R1 sys_irq", int'(sys_irq), 0);
        chk("R1 rdata", int'(bus_rdata), 0);

        // table walk on the system counter
        for (int i = 0; i < NVEC; i++) begin
            idle(int'(VEC[i][25:22]));
            acc(VEC[i][21], VEC[i][20:17], VEC[i][16:1]);
            if (!VEC[i][21])
                chk({VREQ[i], " rdata"}, int'(bus_rdata), int'(VEC[i][16:1]));
            chk({VREQ[i], " sys_irq"}, int'(sys_irq), int'(VEC[i][0]));
        end

        // R2: processor counter 0, limit 3 -> interrupt on edge 4
        acc(1'b1, 4'd0, 16'd3);
        idle(3);
        chk("R2 cpu0 before", int'(cpu_irq[0]), 0);
        idle(1);
        chk("R2 cpu0 at L+1", int'(cpu_irq[0]), 1);
        chk("R2 cpu1 quiet", int'(cpu_irq[1]), 0);
        acc(1'b0, 4'd0, 16'd0);
        chk("R3 cpu0 limit", int'(bus_rdata), 3);
        chk("R3 cpu0 ack", int'(cpu_irq[0]), 0);

        // R9: user mode on counter 0
        acc(1'b1, 4'd11, 16'd1);
        acc(1'b1, 4'd0, 16'd3);
        idle(10);
        acc(1'b0, 4'd1, 16'd0);
        chk("R9 free-run count", int'(bus_rdata), 10);
        acc(1'b0, 4'd11, 16'd0);
        chk("R9 mode readback", int'(bus_rdata), 1);
        idle(243);
        acc(1'b0, 4'd1, 16'd0);
        chk("R9 count at max", int'(bus_rdata), 255);
        acc(1'b0, 4'd1, 16'd0);
        chk("R9 wrapped", int'(bus_rdata), 0);
        chk("R9 no irq in user mode", int'(cpu_irq[0]), 0);
        acc(1'b1, 4'd11, 16'd0);
        idle(1);
        chk("R9 timer again, before", int'(cpu_irq[0]), 0);
        idle(1);
        chk("R9 timer again, match", int'(cpu_irq[0]), 1);

        // R10: unmapped words and idle read data
        acc(1'b0, 4'd7, 16'd0);
        chk("R10 cpu word3", int'(bus_rdata), 0);
        acc(1'b0, 4'd12, 16'd0);
        chk("R10 unused block", int'(bus_rdata), 0);
        acc(1'b0, 4'd0, 16'd0);
        chk("R10 cpu0 limit", int'(bus_rdata), 3);
        idle(1);
        chk("R10 idle rdata", int'(bus_rdata), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule